// File: doc/BRIEF.md
# Bit-Serial Add/Subtract Unit

This block adds or subtracts two small binary operands one bit per clock. Both operands sit in right-shifting registers. On every working cycle the low bits of the two registers meet a stored carry in a one-bit full adder, and the sum bit is pushed into the top of the first operand register. When the pass is over, that register holds the result in place of the first operand, and the carry flop holds the last carry out. Subtraction computes the first operand minus the second by inverting the second operand's serial bit before the adder and starting the carry at 1, which adds the two's complement.

A controller with three states sequences the work. ST_IDLE waits. A load request in ST_IDLE writes both operands and sets the carry from the mode select; this is the IDLE->IDLE load transition. A start request in ST_IDLE latches the mode, sets the carry and takes IDLE->RUN. ST_RUN shifts once per cycle and leaves on its last shift through RUN->DONE. ST_DONE raises the done flag for one cycle and returns through DONE->IDLE. The second operand register feeds its serial output back into its own top bit, so it is unchanged after a pass and can be reused by another start without a reload.

Top module: `serial_addsub`

## Requirements
- R1: After reset the result and the carry read 0, done reads 0 and the unit is idle.
- R2: A load request while idle writes a_in and b_in into the two operand registers and sets the carry to the value of sub_i (0 for add, 1 for subtract) on the same clock edge.
- R3: A start request while idle latches sub_i as the mode for the whole pass and sets the carry to that same value; the first shift happens on the next edge.
- R4: On each working cycle the result register moves right by one bit and its MSB receives a XOR b' XOR c, where a and b are the operand LSBs, b' is b inverted in subtract mode, and c is the stored carry; the new carry is the majority of a, b' and c.
- R5: A pass makes exactly WIDTH shifts; done is high for exactly one cycle, the cycle right after the last shift, and the unit is idle again on the following edge.
- R6: After a pass the result equals (A + B) mod 2^WIDTH and carry equals the carry out of that sum for add, or (A - B) mod 2^WIDTH with carry 1 exactly when A >= B for subtract.
- R7: The second operand register rotates during a pass and holds its loaded value afterwards, so a second start with no load uses the same B.
- R8: Load and start requests during RUN or DONE are ignored.
- R9: When load and start are both asserted while idle, the load is performed and no pass begins.
- R10: While idle with neither load nor start, the result and the carry hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Parallel load request for both operands |
| start_i | input | 1 | Begin a pass |
| sub_i | input | 1 | 1 selects subtract, 0 selects add |
| a_in | input | WIDTH | First operand load value |
| b_in | input | WIDTH | Second operand load value |
| result_o | output | WIDTH | Content of the first operand register (result after a pass) |
| carry_o | output | 1 | Stored carry |
| done_o | output | 1 | One-cycle pulse after the last shift |

## Verification
The add case 0101 + 0111 is followed shift by shift, which separates the sum path into the MSB from the carry path, since the intermediate register and carry values differ per bit. Subtraction is tried with A greater than, less than and equal to B, which tells apart a missing inversion of B, a wrong carry preset and a wrong borrow sense. A restart without reload exposes any damage to B's recirculation, and requests raised while busy or together with load expose broken state gating. A behavioural model compares result, carry and done on every cycle across all of these and a sweep of further operand pairs.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } addsub_state_e;
endpackage

// File: rtl/addsub_shreg.sv
module addsub_shreg #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    output logic [WIDTH-1:0] q,
    output logic             ser_out
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= par_in;
        end else if (shift) begin
            q <= {ser_in, q[WIDTH-1:1]};
        end
    end

    assign ser_out = q[0];
endmodule

// File: rtl/addsub_bitcell.sv
module addsub_bitcell (
    input  logic a_bit,
    input  logic b_bit,
    input  logic invert_b,
    input  logic cin,
    output logic sum,
    output logic cout
);
    logic b_eff;

    always_comb begin
        b_eff = b_bit ^ invert_b;
        sum   = a_bit ^ b_eff ^ cin;
        cout  = (a_bit & b_eff) | (a_bit & cin) | (b_eff & cin);
    end
endmodule

// File: rtl/addsub_ctrl.sv
module addsub_ctrl
    import addsub_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic start_i,
    input  logic sub_i,
    output logic load_go,
    output logic start_go,
    output logic shift_en,
    output logic done_o,
    output logic mode_sub
);
    localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    addsub_state_e state, state_nx;
    logic [CW-1:0] cnt;
    logic          last_shift;

    assign last_shift = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            mode_sub <= 1'b0;
        end else begin
            state <= state_nx;
            if (start_go) begin
                cnt      <= '0;
                mode_sub <= sub_i;
            end else if (shift_en) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start_i && !load_i) state_nx = ST_RUN;
            ST_RUN:  if (last_shift)         state_nx = ST_DONE;
            ST_DONE:                         state_nx = ST_IDLE;
            default:                         state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        load_go  = 1'b0;
        start_go = 1'b0;
        shift_en = 1'b0;
        done_o   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                load_go  = load_i;
                start_go = start_i && !load_i;
            end
            ST_RUN:  shift_en = 1'b1;
            ST_DONE: done_o   = 1'b1;
            default: ;
        endcase
    end

    // R5: done lasts a single cycle
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: no request is honoured outside idle
    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (!load_go && !start_go));

    // R9: load beats start
    p_load_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && load_i && start_i) |=> (state == ST_IDLE));
endmodule

// File: rtl/serial_addsub.sv
module serial_addsub #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             start_i,
    input  logic             sub_i,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o,
    output logic             done_o
);
    localparam int RCW = $clog2(WIDTH + 1) + 1;

    logic load_go, start_go, shift_en, mode_sub;
    logic a_ser, b_ser, sum_bit, cout_bit;
    logic [WIDTH-1:0] a_q, b_q;
    logic carry_q;

    addsub_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_i),
        .start_i  (start_i),
        .sub_i    (sub_i),
        .load_go  (load_go),
        .start_go (start_go),
        .shift_en (shift_en),
        .done_o   (done_o),
        .mode_sub (mode_sub)
    );

    addsub_shreg #(.WIDTH(WIDTH)) u_areg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_go),
        .shift   (shift_en),
        .par_in  (a_in),
        .ser_in  (sum_bit),
        .q       (a_q),
        .ser_out (a_ser)
    );

    addsub_shreg #(.WIDTH(WIDTH)) u_breg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_go),
        .shift   (shift_en),
        .par_in  (b_in),
        .ser_in  (b_ser),
        .q       (b_q),
        .ser_out (b_ser)
    );

    addsub_bitcell u_cell (
        .a_bit    (a_ser),
        .b_bit    (b_ser),
        .invert_b (mode_sub),
        .cin      (carry_q),
        .sum      (sum_bit),
        .cout     (cout_bit)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
        end else if (load_go || start_go) begin
            carry_q <= sub_i;
        end else if (shift_en) begin
            carry_q <= cout_bit;
        end
    end

    assign result_o = a_q;
    assign carry_o  = carry_q;

    // Checker state: number of shifts since the last start
    logic [RCW-1:0] run_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)        run_cnt <= '0;
        else if (start_go) run_cnt <= '0;
        else if (shift_en) run_cnt <= run_cnt + 1'b1;
    end

    // R2: load sets carry from the mode select
    p_load_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_go |=> (carry_q == $past(sub_i)) && (a_q == $past(a_in)) && (b_q == $past(b_in)));

    // R4: sum bit lands in the MSB, rest moves down
    p_shift_msb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (a_q[WIDTH-1] == $past(sum_bit)) && (a_q[WIDTH-2:0] == $past(a_q[WIDTH-1:1])));

    // R5: done only after exactly WIDTH shifts
    p_run_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (run_cnt == RCW'(WIDTH)));

    // R7: B rotates while working
    p_b_rotate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (b_q == {$past(b_q[0]), $past(b_q[WIDTH-1:1])}));

    // R10: idle with no request holds state
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !load_go && !start_go) |=> ($stable(a_q) && $stable(carry_q) && $stable(b_q)));
endmodule

// File: tb/sim_serial_addsub.sv
module sim_serial_addsub;
    localparam int W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load_i = 1'b0, start_i = 1'b0, sub_i = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] result_o;
    logic carry_o, done_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    serial_addsub #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_i(start_i), .sub_i(sub_i),
        .a_in(a_in), .b_in(b_in), .result_o(result_o), .carry_o(carry_o), .done_o(done_o)
    );

    // Behavioural reference model
    int m_st = 0;   // 0 idle, 1 run, 2 done
    int m_a = 0, m_b = 0, m_c = 0, m_n = 0, m_sub = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_a = 0; m_b = 0; m_c = 0; m_n = 0; m_sub = 0;
        end else begin
            case (m_st)
                0: begin
                    if (load_i) begin
                        m_a = int'(a_in); m_b = int'(b_in); m_c = int'(sub_i);
                    end else if (start_i) begin
                        m_c = int'(sub_i); m_sub = int'(sub_i); m_n = 0; m_st = 1;
                    end
                end
                1: begin
                    int ab, bb, s, nc;
                    ab = m_a % 2;
                    bb = (m_b % 2) ^ m_sub;
                    s  = ab ^ bb ^ m_c;
                    nc = (ab + bb + m_c) >= 2 ? 1 : 0;
                    m_b = (m_b / 2) + ((m_b % 2) << (W - 1));
                    m_a = (m_a / 2) + (s << (W - 1));
                    m_c = nc;
                    m_n = m_n + 1;
                    if (m_n == W) m_st = 2;
                end
                default: m_st = 0;
            endcase
        end
    end

    // Cycle-by-cycle comparison (R4 model)
    always @(negedge clk) begin
        if (rst_n) begin
            total++;
            if (int'(result_o) != m_a || int'(carry_o) != m_c || int'(done_o) != (m_st == 2 ? 1 : 0)) begin
                bad++;
                $display("FAIL R4 model cycle %0d: got res=%0d c=%0d d=%0d exp res=%0d c=%0d d=%0d",
                         cyc, result_o, carry_o, done_o, m_a, m_c, (m_st == 2));
            end
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d exp %0d", tag, got, exp);
        end
    endtask

    task automatic do_load(input int a, input int b, input bit s);
        @(negedge clk);
        a_in = W'(a); b_in = W'(b); sub_i = s; load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    // start, then wait W shifts; returns at the negedge where done should be high
    task automatic do_pass(input bit s);
        @(negedge clk);
        sub_i = s; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < W; i++) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int exp_a[4] = '{2, 1, 8, 12};
        int exp_c[4] = '{1, 1, 1, 0};
        repeat (3) @(negedge clk);
        // R1
        chk("R1 result after reset", int'(result_o), 0);
        chk("R1 carry after reset", int'(carry_o), 0);
        chk("R1 done after reset", int'(done_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: load in subtract mode presets carry
        do_load(5, 7, 1'b1);
        chk("R2 A loaded", int'(result_o), 5);
        chk("R2 carry preset sub", int'(carry_o), 1);
        do_load(5, 7, 1'b0);
        chk("R2 carry clear add", int'(carry_o), 0);

        // R3/R4: step-by-step add 0101 + 0111
        @(negedge clk);
        sub_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R3 carry set at start", int'(carry_o), 0);
        chk("R3 no done yet", int'(done_o), 0);
        for (int i = 0; i < W; i++) begin
            @(negedge clk);
            chk($sformatf("R4 A after shift %0d", i + 1), int'(result_o), exp_a[i]);
            chk($sformatf("R4 carry after shift %0d", i + 1), int'(carry_o), exp_c[i]);
            if (i < W - 1) chk("R5 done low mid pass", int'(done_o), 0);
        end
        chk("R5 done after last shift", int'(done_o), 1);
        chk("R6 add result", int'(result_o), 12);
        @(negedge clk);
        chk("R5 done one cycle only", int'(done_o), 0);

        // R7: restart with the same B: 12 + 7 = 19 -> 3 carry 1
        do_pass(1'b0);
        chk("R7 reuse B result", int'(result_o), 3);
        chk("R7 reuse B carry", int'(carry_o), 1);

        // R6 subtract cases
        do_load(5, 7, 1'b1); do_pass(1'b1);
        chk("R6 sub 5-7 result", int'(result_o), 14);
        chk("R6 sub 5-7 borrow", int'(carry_o), 0);
        do_load(7, 5, 1'b1); do_pass(1'b1);
        chk("R6 sub 7-5 result", int'(result_o), 2);
        chk("R6 sub 7-5 carry", int'(carry_o), 1);
        do_load(9, 9, 1'b1); do_pass(1'b1);
        chk("R6 sub equal result", int'(result_o), 0);
        chk("R6 sub equal carry", int'(carry_o), 1);

        // R8: requests while busy are ignored
        do_load(3, 4, 1'b0);
        @(negedge clk);
        sub_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        a_in = 4'hF; b_in = 4'hF; load_i = 1'b1; start_i = 1'b1;
        for (int i = 0; i < W; i++) @(negedge clk);
        load_i = 1'b0; start_i = 1'b0;
        chk("R8 busy load ignored result", int'(result_o), 7);
        chk("R8 done still on time", int'(done_o), 1);
        @(negedge clk);

        // R9: load and start together -> only load
        @(negedge clk);
        a_in = 4'd6; b_in = 4'd1; sub_i = 1'b0; load_i = 1'b1; start_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0; start_i = 1'b0;
        repeat (W + 1) @(negedge clk);
        chk("R9 load taken, no pass", int'(result_o), 6);
        chk("R9 no done", int'(done_o), 0);

        // R10: idle hold
        repeat (3) @(negedge clk);
        chk("R10 idle hold result", int'(result_o), 6);
        chk("R10 idle hold carry", int'(carry_o), 0);

        // R6 sweep
        for (int k = 0; k < 24; k++) begin
            int a, b;
            bit s;
            a = (k * 7 + 3) % 16; b = (k * 5 + 11) % 16; s = k[0];
            do_load(a, b, s); do_pass(s);
            if (s) begin
                chk("R6 sweep sub", int'(result_o), (a - b + 16) % 16);
                chk("R6 sweep sub carry", int'(carry_o), (a >= b) ? 1 : 0);
            end else begin
                chk("R6 sweep add", int'(result_o), (a + b) % 16);
                chk("R6 sweep add carry", int'(carry_o), (a + b) >= 16 ? 1 : 0);
            end
        end

        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule